// File: doc/BRIEF.md
# Matrix Key Scanner

This block reads a keypad wired as a grid of six drive rows and five sense columns, giving up to thirty keys. It waits with the rows at an idle level. When a sense column goes high, it runs one scan lasting a fixed number of oscillator ticks. In that scan every row is pulsed high twice, in two passes, and all five columns are sampled in the middle of each pulse. A scan counts as valid only when both passes return the same key set and that set is not empty. The valid result is then latched into a key buffer and an active-low interrupt is raised.

While the interrupt is low the buffer is frozen and no new scan starts. The host's serial interface ends the lockout with a one-cycle read-done pulse. A failed scan is dropped without a trace. If a key is still held, the idle detector starts a new scan at once, so the block keeps retrying until a scan succeeds.

Two mode inputs hand drive rows 1 and 2 back to segment use; those rows are then never driven and their key bits always read zero. A two-bit sleep code sets which rows idle high. In sleep the oscillator enable is dropped except while a scan runs, so only keys on the rows that idle high can wake the block.

Top module: `matrix_key_scanner`

## Requirements
- R1: After reset, irq_no is 1, key_o is all zero, osc_en_o is 1 and, with sleep code 0 and no segment rows, drive_o is all ones.
- R2: A scan starts within three clock cycles of a sense input going high while idle. irq_no falls 582 counted ticks after the scan starts (582 or 583 ticks after the press). A press released before the scan ends is not stored.
- R3: During a scan at most one row is high at a time, and each usable row goes high exactly twice. The key in row r (1..6) and column c (1..5) is stored in key_o bit (r-1)*5+(c-1).
- R4: When the two passes differ for any key, the scan stores nothing and leaves irq_no high. If a key is still pressed, new scans start until one succeeds.
- R5: Once irq_no is low, key_o and irq_no stay unchanged until rd_done_i is pulsed; that pulse returns irq_no to 1. A rd_done_i pulse while irq_no is high changes nothing.
- R6: Keys pressed together in different rows and columns are all stored by the same scan.
- R7: row_seg_i bit 0 turns row 1 into a segment row and bit 1 does the same for row 2. A segment row is held low on drive_o and its five key bits read zero. A matrix with only segment-row keys pressed never starts a scan.
- R8: Sleep code 1 idles only row 6 high, code 2 rows 5 and 6, and code 3 rows 4 to 6; code 0 idles all rows high. In any sleep code, osc_en_o is 1 only while a scan runs. A press on a low-idling row starts nothing, and a press on a high-idling row raises osc_en_o and runs a normal scan.
- R9: Reset clears the key buffer and releases irq_no, even while locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse per oscillator period |
| sleep_i | input | 2 | Sleep code: 0 normal, 1..3 sleep idle patterns |
| row_seg_i | input | 2 | Per-row segment takeover for rows 1 and 2 |
| rd_done_i | input | 1 | Pulse when the host has read the key data |
| sense_i | input | 5 | Matrix sense columns, asynchronous |
| drive_o | output | 6 | Matrix drive rows |
| osc_en_o | output | 1 | Oscillator run request |
| key_o | output | 30 | Key buffer, one bit per key |
| irq_no | output | 1 | Key data ready, active low |

## Verification
The assertions watch, on every cycle, that a scan drives at most one row at a time and that the final tick of a scan falls after both passes are complete. They also check that the interrupt and buffer hold still until a read-done arrives, that a pass mismatch never raises the interrupt, and that a segment row never contributes key bits. Other behaviour needs the bench's directed scenarios with a modelled key matrix: the exact tick count from press to interrupt, the bit mapping, and the retry after a bounce. The same goes for rejecting presses that are too short, the lockout against a changed key, the sleep wake-up rows and the reset clearing a held result.

// File: rtl/kscan_pkg.sv
package kscan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_LOCK = 2'd2
  } scan_state_e;
endpackage

// File: rtl/kscan_timing.sv
module kscan_timing #(
  parameter int ROWS       = 6,
  parameter int SCAN_TICKS = 582,
  localparam int RW        = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          adv_i,
  output logic [RW-1:0] row_o,
  output logic          pass_o,
  output logic          pulse_o,
  output logic          sample_o,
  output logic          done_o
);
  localparam int SLOTS       = 2 * ROWS;
  localparam int SLOT_TICKS  = SCAN_TICKS / SLOTS;
  localparam int PULSE_TICKS = SLOT_TICKS / 2;
  localparam int SAMPLE_AT   = PULSE_TICKS / 2;
  localparam int TW          = $clog2(SCAN_TICKS);
  localparam int SW          = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1;
  localparam int LW          = $clog2(SLOTS + 1);

  logic [TW-1:0] tcnt_q;
  logic [SW-1:0] sub_q;
  logic [LW-1:0] slot_q;
  logic [LW-1:0] row_l;
  logic          in_slot;

  assign in_slot = slot_q < LW'(SLOTS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tcnt_q <= '0;
      sub_q  <= '0;
      slot_q <= '0;
    end else if (start_i) begin
      tcnt_q <= '0;
      sub_q  <= '0;
      slot_q <= '0;
    end else if (adv_i) begin
      tcnt_q <= (tcnt_q == TW'(SCAN_TICKS - 1)) ? '0 : tcnt_q + 1'b1;
      if (in_slot) begin
        if (sub_q == SW'(SLOT_TICKS - 1)) begin
          sub_q  <= '0;
          slot_q <= slot_q + 1'b1;
        end else begin
          sub_q <= sub_q + 1'b1;
        end
      end
    end
  end

  // pass 0 covers slots 0..ROWS-1, pass 1 the rest
  always_comb begin
    row_l = (slot_q < LW'(ROWS)) ? slot_q : slot_q - LW'(ROWS);
  end

  assign row_o    = row_l[RW-1:0];
  assign pass_o   = !(slot_q < LW'(ROWS));
  assign pulse_o  = in_slot && (sub_q < SW'(PULSE_TICKS));
  assign sample_o = adv_i && in_slot && (sub_q == SW'(SAMPLE_AT));
  assign done_o   = adv_i && (tcnt_q == TW'(SCAN_TICKS - 1));

  assert_passes_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (slot_q == LW'(SLOTS)));

  assert_sample_in_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> (pulse_o && row_l < LW'(ROWS)));
endmodule

// File: rtl/kscan_capture.sv
module kscan_capture #(
  parameter int ROWS  = 6,
  parameter int COLS  = 5,
  localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int KEYS = ROWS * COLS
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic            sample_i,
  input  logic            pass_i,
  input  logic [RW-1:0]   row_i,
  input  logic [COLS-1:0] sense_i,
  input  logic [ROWS-1:0] row_en_i,
  output logic [KEYS-1:0] keys_o,
  output logic            match_o
);
  logic [KEYS-1:0] first_m;
  logic [KEYS-1:0] second_m;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [COLS-1:0] first_q;
    logic [COLS-1:0] second_q;
    logic            hit;

    assign hit = sample_i && (row_i == RW'(r));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        first_q  <= '0;
        second_q <= '0;
      end else if (clear_i) begin
        first_q  <= '0;
        second_q <= '0;
      end else if (hit) begin
        if (pass_i) second_q <= sense_i;
        else        first_q  <= sense_i;
      end
    end

    assign first_m[r*COLS +: COLS]  = first_q  & {COLS{row_en_i[r]}};
    assign second_m[r*COLS +: COLS] = second_q & {COLS{row_en_i[r]}};
  end

  assign keys_o  = second_m;
  assign match_o = (first_m == second_m);

  assert_clear_empty_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !sample_i) |=> (keys_o == '0 && match_o));
endmodule

// File: rtl/kscan_ctrl.sv
module kscan_ctrl
  import kscan_pkg::*;
#(
  parameter int KEYS = 30
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            key_seen_i,
  input  logic            done_i,
  input  logic            match_i,
  input  logic [KEYS-1:0] keys_i,
  input  logic            rd_done_i,
  output logic            start_o,
  output logic            busy_o,
  output logic [KEYS-1:0] keys_o,
  output logic            irq_no
);
  scan_state_e state_q;

  assign start_o = (state_q == ST_IDLE) && key_seen_i;
  assign busy_o  = (state_q == ST_SCAN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      keys_o  <= '0;
      irq_no  <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: if (key_seen_i) state_q <= ST_SCAN;
        ST_SCAN: begin
          if (done_i) begin
            if (match_i && |keys_i) begin
              state_q <= ST_LOCK;
              keys_o  <= keys_i;
              irq_no  <= 1'b0;
            end else begin
              state_q <= ST_IDLE; // rescans via idle detect if still held
            end
          end
        end
        ST_LOCK: begin
          if (rd_done_i) begin
            state_q <= ST_IDLE;
            irq_no  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_lock_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_no && !rd_done_i) |=> (!irq_no && $stable(keys_o)));

  assert_mismatch_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && done_i && !match_i) |=> irq_no);

  assert_irq_from_scan_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_no) |-> $past(busy_o && done_i));
endmodule

// File: rtl/matrix_key_scanner.sv
module matrix_key_scanner #(
  parameter int ROWS       = 6,
  parameter int COLS       = 5,
  parameter int SEG_ROWS   = 2,
  parameter int SCAN_TICKS = 582,
  localparam int KEYS      = ROWS * COLS,
  localparam int RW        = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic [1:0]          sleep_i,
  input  logic [SEG_ROWS-1:0] row_seg_i,
  input  logic                rd_done_i,
  input  logic [COLS-1:0]     sense_i,
  output logic [ROWS-1:0]     drive_o,
  output logic                osc_en_o,
  output logic [KEYS-1:0]     key_o,
  output logic                irq_no
);
  logic [COLS-1:0] sense_s1_q, sense_s2_q;
  logic [ROWS-1:0] row_en, idle_lvl, pulse_lvl;
  logic [RW-1:0]   row;
  logic            pass, pulse, sample, done;
  logic            start, busy, adv, match;
  logic [KEYS-1:0] scan_keys;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sense_s1_q <= '0;
      sense_s2_q <= '0;
    end else begin
      sense_s1_q <= sense_i;
      sense_s2_q <= sense_s1_q;
    end
  end

  assign row_en = ~{{(ROWS-SEG_ROWS){1'b0}}, row_seg_i};

  // sleep code n leaves the top n rows idling high
  always_comb begin
    if (sleep_i == 2'd0) idle_lvl = '1;
    else                 idle_lvl = ~({ROWS{1'b1}} >> sleep_i);
  end

  always_comb begin
    pulse_lvl = '0;
    if (pulse) pulse_lvl[row] = 1'b1;
  end

  assign drive_o  = (busy ? pulse_lvl : idle_lvl) & row_en;
  assign osc_en_o = (sleep_i == 2'd0) || busy;
  assign adv      = tick_i && busy;

  kscan_timing #(
    .ROWS       (ROWS),
    .SCAN_TICKS (SCAN_TICKS)
  ) u_timing (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .adv_i    (adv),
    .row_o    (row),
    .pass_o   (pass),
    .pulse_o  (pulse),
    .sample_o (sample),
    .done_o   (done)
  );

  kscan_capture #(
    .ROWS (ROWS),
    .COLS (COLS)
  ) u_capture (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (start),
    .sample_i (sample),
    .pass_i   (pass),
    .row_i    (row),
    .sense_i  (sense_s2_q),
    .row_en_i (row_en),
    .keys_o   (scan_keys),
    .match_o  (match)
  );

  kscan_ctrl #(
    .KEYS (KEYS)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .key_seen_i (|sense_s2_q),
    .done_i     (done),
    .match_i    (match),
    .keys_i     (scan_keys),
    .rd_done_i  (rd_done_i),
    .start_o    (start),
    .busy_o     (busy),
    .keys_o     (key_o),
    .irq_no     (irq_no)
  );

  assert_one_row_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> $onehot0(drive_o));

  assert_seg_keys_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(irq_no) && $past(row_seg_i[0])) |-> (key_o[COLS-1:0] == '0));
endmodule

// File: tb/matrix_key_scanner_test.sv
`timescale 1ns/1ps
module matrix_key_scanner_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_q = 1'b0;
  logic        tick_i;
  logic [1:0]  sleep_i = 2'd0;
  logic [1:0]  row_seg_i = 2'd0;
  logic        rd_done_i = 1'b0;
  logic [4:0]  sense_i;
  logic [5:0]  drive_o;
  logic        osc_en_o;
  logic [29:0] key_o;
  logic        irq_no;

  logic [29:0] press = '0;
  logic [1:0]  div_q = '0;
  int          tick_cnt = 0;
  int          rise_cnt = 0;
  logic        prev_row3 = 1'b0;
  int          n_tests = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  matrix_key_scanner uut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .sleep_i   (sleep_i),
    .row_seg_i (row_seg_i),
    .rd_done_i (rd_done_i),
    .sense_i   (sense_i),
    .drive_o   (drive_o),
    .osc_en_o  (osc_en_o),
    .key_o     (key_o),
    .irq_no    (irq_no)
  );

  // oscillator: one tick per 4 clocks, stopped when not enabled
  always @(negedge clk) begin
    div_q  <= div_q + 2'd1;
    tick_q <= (div_q == 2'd3);
  end
  assign tick_i = tick_q && osc_en_o;

  always @(posedge clk) if (tick_i) tick_cnt <= tick_cnt + 1;

  always @(negedge clk) begin
    if (drive_o[2] && !prev_row3 && irq_no) rise_cnt <= rise_cnt + 1;
    prev_row3 <= drive_o[2];
  end

  // key matrix model: sense column c high if a driven row has key c pressed
  always_comb begin
    sense_i = '0;
    for (int r = 0; r < 6; r++)
      for (int c = 0; c < 5; c++)
        if (drive_o[r] && press[r*5+c]) sense_i[c] = 1'b1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_irq(input int max_cyc, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < max_cyc; i++) begin
      @(negedge clk);
      if (!irq_no) begin seen = 1'b1; break; end
    end
  endtask

  task automatic read_out();
    @(negedge clk) rd_done_i = 1'b1;
    @(negedge clk) rd_done_i = 1'b0;
  endtask

  task automatic wait_ticks(input int n);
    int t0;
    t0 = tick_cnt;
    while (tick_cnt - t0 < n) @(negedge clk);
  endtask

  task automatic t_reset();
    check(irq_no == 1'b1, "R1", "irq_no after reset", 32'(irq_no), 32'd1);
    check(key_o == '0, "R1", "key_o after reset", 32'(key_o), 32'd0);
    check(drive_o == 6'h3F, "R1", "idle drive", 32'(drive_o), 32'h3F);
    check(osc_en_o == 1'b1, "R1", "osc_en_o", 32'(osc_en_o), 32'd1);
  endtask

  task automatic t_single();
    bit seen;
    int t0, dt;
    clocks(1);
    rise_cnt = 0;
    t0 = tick_cnt;
    press = 30'd1 << 12;  // row 3, column 3
    wait_irq(4000, seen);
    dt = tick_cnt - t0;
    check(seen, "R2", "irq after single press", 32'(irq_no), 32'd0);
    check(dt >= 582 && dt <= 583, "R2", "ticks press to irq", 32'(dt), 32'd582);
    check(key_o == (30'd1 << 12), "R3", "key bit mapping", 32'(key_o), 32'h1000);
    check(rise_cnt == 2, "R3", "row 3 pulses per scan", 32'(rise_cnt), 32'd2);
    press = '0;
    read_out();
    clocks(1);
    check(irq_no == 1'b1, "R5", "irq released by read", 32'(irq_no), 32'd1);
  endtask

  task automatic t_multi();
    bit seen;
    logic [29:0] exp;
    exp = (30'd1 << 0) | (30'd1 << 7) | (30'd1 << 29);
    press = exp;
    wait_irq(4000, seen);
    check(seen && key_o == exp, "R6", "simultaneous keys", 32'(key_o), 32'(exp));
    press = '0;
    read_out();
  endtask

  task automatic t_lock();
    bit seen;
    press = 30'd1 << 3;
    wait_irq(4000, seen);
    check(seen && key_o == (30'd1 << 3), "R5", "first result", 32'(key_o), 32'h8);
    press = 30'd1 << 20;
    clocks(7000);
    check(irq_no == 1'b0, "R5", "irq held during lock", 32'(irq_no), 32'd0);
    check(key_o == (30'd1 << 3), "R5", "buffer frozen during lock", 32'(key_o), 32'h8);
    read_out();
    wait_irq(4000, seen);
    check(seen && key_o == (30'd1 << 20), "R5", "scan after read", 32'(key_o), 32'h100000);
    press = '0;
    read_out();
    clocks(2);
    read_out();  // no lock: ignored
    clocks(2);
    check(irq_no == 1'b1 && key_o == (30'd1 << 20), "R5", "stray read ignored",
          32'(key_o), 32'h100000);
  endtask

  task automatic t_bounce();
    bit seen;
    int t0, dt;
    t0 = tick_cnt;
    press = 30'd1 << 0;
    wait_ticks(150);
    press = '0;
    clocks(3000);
    check(irq_no == 1'b1, "R2", "short press not stored", 32'(irq_no), 32'd1);
    check(key_o == (30'd1 << 20), "R4", "buffer untouched by bad scan", 32'(key_o), 32'h100000);
    t0 = tick_cnt;
    press = 30'd1 << 0;
    wait_ticks(150);
    press = '0;
    wait_ticks(350);
    press = 30'd1 << 0;   // held again: first scan mismatches, retry succeeds
    wait_irq(6000, seen);
    dt = tick_cnt - t0;
    check(seen && key_o == 30'd1, "R4", "retry after mismatch", 32'(key_o), 32'd1);
    check(dt >= 2 * 582, "R4", "retry took a second scan", 32'(dt), 32'd1164);
    press = '0;
    read_out();
  endtask

  task automatic t_seg();
    bit seen;
    row_seg_i = 2'b01;
    clocks(2);
    check(drive_o == 6'h3E, "R7", "segment row 1 low", 32'(drive_o), 32'h3E);
    press = (30'd1 << 1) | (30'd1 << 8);
    wait_irq(4000, seen);
    check(seen && key_o == (30'd1 << 8), "R7", "row 1 keys dropped", 32'(key_o), 32'h100);
    press = '0;
    read_out();
    row_seg_i = 2'b11;
    press = (30'd1 << 2) | (30'd1 << 7);
    clocks(3000);
    check(irq_no == 1'b1, "R7", "segment-only keys start nothing", 32'(irq_no), 32'd1);
    press = (30'd1 << 2) | (30'd1 << 7) | (30'd1 << 11);
    wait_irq(4000, seen);
    check(seen && key_o == (30'd1 << 11), "R7", "rows 1-2 masked", 32'(key_o), 32'h800);
    press = '0;
    read_out();
    row_seg_i = 2'b00;
  endtask

  task automatic t_sleep();
    bit seen;
    sleep_i = 2'd1;
    clocks(2);
    check(drive_o == 6'h20, "R8", "sleep 1 idle rows", 32'(drive_o), 32'h20);
    check(osc_en_o == 1'b0, "R8", "oscillator stopped", 32'(osc_en_o), 32'd0);
    sleep_i = 2'd3;
    clocks(1);
    check(drive_o == 6'h38, "R8", "sleep 3 idle rows", 32'(drive_o), 32'h38);
    sleep_i = 2'd1;
    press = 30'd1 << 4;
    clocks(3000);
    check(irq_no == 1'b1 && osc_en_o == 1'b0, "R8", "low row does not wake",
          32'({irq_no, osc_en_o}), 32'h2);
    press = 30'd1 << 27;
    clocks(6);
    check(osc_en_o == 1'b1, "R8", "wake on high row", 32'(osc_en_o), 32'd1);
    wait_irq(4000, seen);
    check(seen && key_o == (30'd1 << 27), "R8", "sleep scan result", 32'(key_o), 32'h8000000);
    clocks(1);
    check(osc_en_o == 1'b0, "R8", "oscillator off after scan", 32'(osc_en_o), 32'd0);
    press = '0;
    read_out();
    sleep_i = 2'd0;
  endtask

  task automatic t_reset_clear();
    bit seen;
    press = 30'd1 << 9;
    wait_irq(4000, seen);
    press = '0;
    check(seen, "R9", "locked before reset", 32'(irq_no), 32'd0);
    rst_ni = 1'b0;
    clocks(3);
    check(key_o == '0 && irq_no == 1'b1, "R9", "reset clears buffer",
          32'({irq_no, key_o}), 32'h40000000);
    rst_ni = 1'b1;
    clocks(2);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    clocks(4);
    rst_ni = 1'b1;
    clocks(2);
    t_reset();
    t_single();
    t_multi();
    t_lock();
    t_bounce();
    t_seg();
    t_sleep();
    t_reset_clear();
    summary();
    $finish;
  end
endmodule